// File: doc/BRIEF.md
# Multi-Device Coefficient Boot Loader

This block is the master-side sequencer that fills a cascade of filter devices from one shared byte-wide EPROM after power-up. On a start pulse it walks the EPROM one segment at a time, segment 0 for itself and segments 1 to N for up to fifteen slave devices, in ascending order. For each segment it drives the four segment-select address lines and a control-select address bit directly above the eight low address lines. It also drives the low address count. One cycle per byte it pulses a write strobe, and at that moment the EPROM byte is passed through to the shared data output. Slaves compare the segment lines against their own code to decide whether the strobe is meant for them.

Each segment starts with two control reads, made with control-select high at low addresses 0 and 1. A three-bit filter-length mode is taken from the second control byte. The control-select bit then drops and the block reads as many coefficients as that mode calls for, from low address 0 upward. That count already includes the extra coefficients a later bank swap needs. One mode code is invalid: no coefficients are fetched for that segment, a sticky error flag is set, and loading continues with the next segment. EPROM access time is modelled as a fixed number of clock cycles per byte. The strobe fires in the last of those cycles.

Top module: `eprom_boot_seq`

## Requirements
- R1: While reset is asserted and after its release, wr_en, busy, done, mode_err and ctl_sel are 0, and lo_addr and seg_addr are 0, until a start is accepted.
- R2: With master_strap_n high the block is a slave: start is ignored, busy stays 0 and no strobe is issued.
- R3: For a device count N sampled at the accepted start, segments 0 through N are loaded in ascending order, and seg_addr carries the segment number during all of its reads.
- R4: Each segment begins with exactly two reads with ctl_sel = 1, at lo_addr 0 and then 1. Every later read of that segment has ctl_sel = 0.
- R5: The coefficient read count follows the mode: 0 gives 32, 1 and 2 give 64, 3 and 4 give 128, and 5 and 6 give 256. Coefficients are read at lo_addr 0, 1, … count−1, so the unused high low-address bits stay 0.
- R6: The mode is bits [6:4] of the control byte read at lo_addr 1. Mode 7 is invalid: that segment gets no coefficient reads, mode_err is set and held until the next accepted start, and loading moves on to the next segment.
- R7: wr_en is high for exactly one cycle per byte, in the ACCESS_CYC-th cycle that the byte's address is driven, and wr_data equals rd_data in that cycle. The gap between strobes is ACCESS_CYC cycles, or ACCESS_CYC+1 right after the second control byte. The first strobe comes ACCESS_CYC cycles after the cycle in which start is presented.
- R8: After the last read of segment N, done rises, busy falls and no further strobes occur. done holds until a new start, which restarts loading from segment 0.
- R9: Changes to dev_count while a load is in progress have no effect on that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master_strap_n | input | 1 | Low selects master operation |
| start | input | 1 | Start pulse, accepted when idle or done |
| dev_count | input | SEG_W | Highest segment to load (number of extra devices) |
| rd_data | input | DATA_W | Byte returned by the EPROM |
| lo_addr | output | LO_W | Low EPROM address |
| ctl_sel | output | 1 | Control-select address bit above lo_addr |
| seg_addr | output | SEG_W | Segment-select EPROM address |
| wr_en | output | 1 | One-cycle write strobe per byte |
| wr_data | output | DATA_W | Byte passed to the devices with the strobe |
| busy | output | 1 | Load in progress |
| done | output | 1 | All requested segments loaded |
| mode_err | output | 1 | An invalid mode was seen during this load |

## Verification
Loads are run with random device counts and a random mode per segment, including the invalid code. This separates the per-mode read counts from one another, and it shows whether an invalid segment is skipped cleanly rather than stalling or reading coefficients. Directed loads cover a single segment, all sixteen segments at the longest mode, an invalid mode on the master's own segment, and a device count changed mid-load. A strap-high start is also tried. Each strobe is compared against the segment, control-bit and low address expected in order. The bench also compares the byte against a computed EPROM image and the strobe spacing against the access time, which catches address-order and timing faults that a final count alone would miss.

// File: rtl/eprom_boot_pkg.sv
package eprom_boot_pkg;

  localparam int unsigned MODE_W       = 3;
  localparam logic [2:0]  MODE_INVALID = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_DECODE,
    ST_COEF,
    ST_DONE
  } boot_state_e;

  // coefficient reads per filter-length mode, bank-swap reserve included
  function automatic int unsigned coef_reads(input logic [MODE_W-1:0] mode);
    int unsigned n;
    case (mode)
      3'd0:       n = 32;
      3'd1, 3'd2: n = 64;
      3'd3, 3'd4: n = 128;
      3'd5, 3'd6: n = 256;
      default:    n = 0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
  parameter int unsigned ACCESS_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic tick
);

  localparam int unsigned CW = (ACCESS_CYC > 2) ? $clog2(ACCESS_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACCESS_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tick = active && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!active) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/boot_addr_gen.sv
module boot_addr_gen #(
  parameter int unsigned LO_W  = 8,
  parameter int unsigned SEG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             seg_inc,
  input  logic             lo_clr,
  input  logic             lo_inc,
  output logic [LO_W-1:0]  lo_addr,
  output logic [SEG_W-1:0] seg_addr
);

  logic [LO_W-1:0]  lo_q,  lo_d;
  logic [SEG_W-1:0] seg_q, seg_d;
  logic             lo_en, seg_en;

  always_comb begin
    lo_d   = lo_q;
    seg_d  = seg_q;
    lo_en  = 1'b0;
    seg_en = 1'b0;
    if (clr_all) begin
      lo_d   = '0;
      seg_d  = '0;
      lo_en  = 1'b1;
      seg_en = 1'b1;
    end else if (seg_inc) begin
      lo_d   = '0;
      seg_d  = seg_q + 1'b1;
      lo_en  = 1'b1;
      seg_en = 1'b1;
    end else if (lo_clr) begin
      lo_d  = '0;
      lo_en = 1'b1;
    end else if (lo_inc) begin
      lo_d  = lo_q + 1'b1;
      lo_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
    end else if (seg_en) begin
      seg_q <= seg_d;
    end
  end

  assign lo_addr  = lo_q;
  assign seg_addr = seg_q;

endmodule

// File: rtl/boot_mode_dec.sv
module boot_mode_dec
  import eprom_boot_pkg::*;
#(
  parameter int unsigned LO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [MODE_W-1:0] mode_in,
  output logic              mode_ok,
  output logic [LO_W-1:0]   last_lo
);

  localparam int unsigned LO_SPAN = 1 << LO_W;

  logic [MODE_W-1:0] mode_q, mode_d;
  int unsigned       reads;

  always_comb begin
    mode_d = mode_q;
    if (cap_en) begin
      mode_d = mode_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (cap_en) begin
      mode_q <= mode_d;
    end
  end

  always_comb begin
    reads = coef_reads(mode_q);
    if (reads > LO_SPAN) begin
      reads = LO_SPAN;
    end
    mode_ok = (mode_q != MODE_INVALID) && (reads != 0);
    last_lo = (reads == 0) ? '0 : LO_W'(reads - 1);
  end

endmodule

// File: rtl/eprom_boot_seq.sv
module eprom_boot_seq
  import eprom_boot_pkg::*;
#(
  parameter int unsigned ACCESS_CYC = 3,
  parameter int unsigned LO_W       = 8,
  parameter int unsigned SEG_W      = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned MODE_LSB   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_strap_n,
  input  logic              start,
  input  logic [SEG_W-1:0]  dev_count,
  input  logic [DATA_W-1:0] rd_data,
  output logic [LO_W-1:0]   lo_addr,
  output logic              ctl_sel,
  output logic [SEG_W-1:0]  seg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              mode_err
);

  localparam logic [LO_W-1:0] CTRL_LAST = LO_W'(1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  boot_state_e      state_q, state_d;
  logic [SEG_W-1:0] dev_lat_q, dev_lat_d;
  logic             err_q, err_d;
  logic             start_ok;
  logic             tick;
  logic             clr_all, seg_inc, lo_clr, lo_inc, cap_en;
  logic             mode_ok;
  logic [LO_W-1:0]  last_lo;
  logic             last_seg;

  assign start_ok = start && !master_strap_n &&
                    ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign last_seg = (seg_addr == dev_lat_q);

  boot_timer #(
    .ACCESS_CYC (ACCESS_CYC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .active ((state_q == ST_CTRL) || (state_q == ST_COEF)),
    .tick   (tick)
  );

  boot_addr_gen #(
    .LO_W  (LO_W),
    .SEG_W (SEG_W)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_all  (clr_all),
    .seg_inc  (seg_inc),
    .lo_clr   (lo_clr),
    .lo_inc   (lo_inc),
    .lo_addr  (lo_addr),
    .seg_addr (seg_addr)
  );

  boot_mode_dec #(
    .LO_W (LO_W)
  ) u_mode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cap_en  (cap_en),
    .mode_in (rd_data[MODE_LSB +: MODE_W]),
    .mode_ok (mode_ok),
    .last_lo (last_lo)
  );

  // next-state and control decode
  always_comb begin
    state_d   = state_q;
    dev_lat_d = dev_lat_q;
    err_d     = err_q;
    clr_all   = 1'b0;
    seg_inc   = 1'b0;
    lo_clr    = 1'b0;
    lo_inc    = 1'b0;
    cap_en    = 1'b0;

    if (start_ok) begin
      state_d   = ST_CTRL;
      dev_lat_d = dev_count;
      err_d     = 1'b0;
      clr_all   = 1'b1;
    end else begin
      case (state_q)
        ST_CTRL: begin
          if (tick) begin
            if (lo_addr == CTRL_LAST) begin
              cap_en  = 1'b1;
              lo_clr  = 1'b1;
              state_d = ST_DECODE;
            end else begin
              lo_inc = 1'b1;
            end
          end
        end
        ST_DECODE: begin
          if (mode_ok) begin
            state_d = ST_COEF;
          end else begin
            err_d = 1'b1;
            if (last_seg) begin
              clr_all = 1'b1;
              state_d = ST_DONE;
            end else begin
              seg_inc = 1'b1;
              state_d = ST_CTRL;
            end
          end
        end
        ST_COEF: begin
          if (tick) begin
            if (lo_addr == last_lo) begin
              if (last_seg) begin
                clr_all = 1'b1;
                state_d = ST_DONE;
              end else begin
                seg_inc = 1'b1;
                state_d = ST_CTRL;
              end
            end else begin
              lo_inc = 1'b1;
            end
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dev_lat_q <= '0;
    end else if (start_ok) begin
      dev_lat_q <= dev_lat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign ctl_sel  = (state_q == ST_CTRL);
  assign wr_en    = tick;
  assign wr_data  = rd_data;
  assign busy     = (state_q == ST_CTRL) || (state_q == ST_DECODE) ||
                    (state_q == ST_COEF);
  assign done     = (state_q == ST_DONE);
  assign mode_err = err_q;

endmodule

// File: rtl/eprom_boot_seq_chk.sv
module eprom_boot_seq_chk #(
  parameter int unsigned LO_W  = 8,
  parameter int unsigned SEG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             master_strap_n,
  input logic             start,
  input logic [LO_W-1:0]  lo_addr,
  input logic             ctl_sel,
  input logic [SEG_W-1:0] seg_addr,
  input logic [SEG_W-1:0] dev_lat,
  input logic             wr_en,
  input logic             busy,
  input logic             done,
  input logic             mode_err
);

  // R7: each strobe lasts one cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R7: the address holds until the byte is strobed
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(wr_en)) |-> $stable(lo_addr));

  // R4: control reads only use low addresses 0 and 1
  a_r4_ctl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_sel |-> (lo_addr <= LO_W'(1)));

  // R3: never beyond the latched last segment
  a_r3_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (seg_addr <= dev_lat));

  // R2: a slave strap keeps the sequencer idle
  a_r2_strap_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (master_strap_n && !busy) |=> !busy);

  // R8: finished means quiet
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_en && !busy && !ctl_sel));

  // R6: the error flag is sticky within a load
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_err && !start) |=> mode_err);

endmodule

bind eprom_boot_seq eprom_boot_seq_chk #(
  .LO_W  (LO_W),
  .SEG_W (SEG_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .master_strap_n (master_strap_n),
  .start          (start),
  .lo_addr        (lo_addr),
  .ctl_sel        (ctl_sel),
  .seg_addr       (seg_addr),
  .dev_lat        (dev_lat_q),
  .wr_en          (wr_en),
  .busy           (busy),
  .done           (done),
  .mode_err       (mode_err)
);

// File: tb/eprom_boot_seq_bench.sv
module eprom_boot_seq_bench;

  localparam int LAT = 3;

  logic       clk;
  logic       rst_n;
  logic       master_strap_n;
  logic       start;
  logic [3:0] dev_count;
  logic [7:0] rd_data;
  logic [7:0] lo_addr;
  logic       ctl_sel;
  logic [3:0] seg_addr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       busy;
  logic       done;
  logic       mode_err;

  int n_cmp;
  int n_bad;
  int cyc;
  logic [2:0] modes [16];
  logic [7:0] salt;

  int exp_seg [4200];
  int exp_ctl [4200];
  int exp_lo  [4200];
  int exp_n;

  eprom_boot_seq #(.ACCESS_CYC(LAT)) u_eprom_boot_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .master_strap_n (master_strap_n),
    .start          (start),
    .dev_count      (dev_count),
    .rd_data        (rd_data),
    .lo_addr        (lo_addr),
    .ctl_sel        (ctl_sel),
    .seg_addr       (seg_addr),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .busy           (busy),
    .done           (done),
    .mode_err       (mode_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] rom_byte(input int seg, input int ctl, input int lo,
                                          input logic [2:0] m, input logic [7:0] s);
    if (ctl == 1 && lo == 1) return {1'b0, m, 4'(seg) ^ 4'hA};
    return 8'(seg * 37 + lo * 11 + ctl * 101) ^ s;
  endfunction

  always_comb rd_data = rom_byte(int'(seg_addr), int'(ctl_sel), int'(lo_addr),
                                 modes[seg_addr], salt);

  function automatic int exp_reads(input logic [2:0] m);
    case (m)
      3'd0: return 32;
      3'd1, 3'd2: return 64;
      3'd3, 3'd4: return 128;
      3'd5, 3'd6: return 256;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic build_exp(input int n);
    exp_n = 0;
    for (int s = 0; s <= n; s++) begin
      for (int c = 0; c < 2; c++) begin
        exp_seg[exp_n] = s; exp_ctl[exp_n] = 1; exp_lo[exp_n] = c; exp_n++;
      end
      for (int k = 0; k < exp_reads(modes[s]); k++) begin
        exp_seg[exp_n] = s; exp_ctl[exp_n] = 0; exp_lo[exp_n] = k; exp_n++;
      end
    end
  endtask

  // one load; change_at > 0 alters dev_count during the load (R9)
  task automatic run_load(input int n, input int change_at);
    int idx, last_cyc, gap_exp, iter;
    bit any_err;
    build_exp(n);
    any_err = 1'b0;
    for (int s = 0; s <= n; s++) if (modes[s] == 3'd7) any_err = 1'b1;
    @(negedge clk);
    dev_count = 4'(n);
    start = 1'b1;
    last_cyc = cyc;
    gap_exp = LAT;
    idx = 0;
    iter = 0;
    while (iter < 20000) begin
      @(negedge clk);
      start = 1'b0;
      iter++;
      if (change_at > 0 && iter == change_at) dev_count = 4'(15 - n);
      if (wr_en) begin
        if (idx < exp_n) begin
          check(int'(seg_addr) == exp_seg[idx], "R3 segment", int'(seg_addr), exp_seg[idx]);
          check(int'(ctl_sel) == exp_ctl[idx], "R4 ctl_sel", int'(ctl_sel), exp_ctl[idx]);
          check(int'(lo_addr) == exp_lo[idx], "R5 lo_addr", int'(lo_addr), exp_lo[idx]);
          check(wr_data == rom_byte(exp_seg[idx], exp_ctl[idx], exp_lo[idx],
                                    modes[exp_seg[idx]], salt),
                "R7 wr_data", int'(wr_data), 0);
          check(cyc - last_cyc == gap_exp, "R7 strobe gap", cyc - last_cyc, gap_exp);
          gap_exp = (exp_ctl[idx] == 1 && exp_lo[idx] == 1) ? LAT + 1 : LAT;
        end
        last_cyc = cyc;
        idx++;
      end
      if (done) break;
    end
    check(done === 1'b1, "R8 done raised", int'(done), 1);
    check(idx == exp_n, "R5 strobe count", idx, exp_n);
    check(mode_err == any_err, "R6 mode_err", int'(mode_err), int'(any_err));
    repeat (5) @(negedge clk);
    check(done && !busy && !wr_en, "R8 done held quiet", int'({done, busy, wr_en}), 4);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0;
    rst_n = 1'b0; master_strap_n = 1'b0; start = 1'b0; dev_count = '0; salt = 8'h5C;
    for (int i = 0; i < 16; i++) modes[i] = 3'd0;
    repeat (4) @(negedge clk);
    check(!wr_en && !busy && !done && !ctl_sel && lo_addr == 0 && seg_addr == 0,
          "R1 in reset", int'({wr_en, busy, done, ctl_sel}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!wr_en && !busy && !done && !mode_err && lo_addr == 0 && seg_addr == 0,
          "R1 after release", int'({wr_en, busy, done, mode_err}), 0);

    // R2: slave strap
    master_strap_n = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      bit seen = 1'b0;
      repeat (40) begin
        @(negedge clk);
        if (busy || wr_en || done) seen = 1'b1;
      end
      check(!seen, "R2 strap ignores start", int'(seen), 0);
    end
    master_strap_n = 1'b0;

    // directed: single segment, shortest mode
    modes[0] = 3'd0;
    run_load(0, 0);
    // directed: invalid mode on the master's own segment (R6), then restart (R8)
    modes[0] = 3'd7; modes[1] = 3'd2;
    run_load(1, 0);
    // directed: all sixteen segments at the longest modes
    for (int i = 0; i < 16; i++) modes[i] = (i % 2 == 0) ? 3'd5 : 3'd6;
    salt = 8'hA3;
    run_load(15, 0);
    // directed: dev_count changed mid-load (R9)
    for (int i = 0; i < 16; i++) modes[i] = 3'd1;
    run_load(2, 30);

    // constrained random loads
    void'($urandom(32'd1234));
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 16; i++) modes[i] = 3'($urandom_range(0, 7));
      salt = 8'($urandom);
      run_load(int'($urandom_range(0, 9)), (r % 3 == 0) ? 50 : 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #760000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule